// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block decides, cycle by cycle, whether a processor with four privilege levels (EL0 lowest, EL3 highest) must divert its program flow. It samples a synchronous exception request, three asynchronous interrupt requests (normal IRQ, fast FIQ and system error), a return strobe, a per-class routing level and the core's current PC and state word. When an exception is accepted, it saves the current state word and PC into registers banked for the target level. It then produces the vector address inside that level's table and the state word the core must adopt.

On a return, it hands back the link address and saved state of the current level. Masks, the stack-pointer choice and the current level all live in the state word, which the core feeds back on `pstate_i`.

Both entry and return complete in one clock cycle. Results appear on registered outputs in the cycle after the request and are marked by a one-cycle `redirect_o` pulse.

State word layout (8 bits): [1:0] exception level, [2] stack select (1 = own level's pointer, 0 = EL0 pointer), [3] system-error mask, [4] IRQ mask, [5] FIQ mask, [7:6] software bits carried unchanged.

Top module: `exc_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted event, `redirect_o`, `pc_o`, `state_o`, `el_o` and `sp_sel_o` are all zero.
- R2: When several exceptions can be taken in the same cycle, the system error wins, then FIQ, then IRQ, then the synchronous request.
- R3: An asynchronous request whose routed level is above the current level is taken even when its mask bit is set.
- R4: An asynchronous request whose routed level equals the current level is taken only when its mask bit (system error bit 3, IRQ bit 4, FIQ bit 5) is clear.
- R5: An asynchronous request whose routed level is below the current level is never taken.
- R6: A route value of 0 means EL1. A synchronous exception targets the greater of its route and the current level. No exception ever targets a level below the current one or EL0.
- R7: On entry, the input state word and PC are stored in the saved-state and link registers of the target level.
- R8: The entry address is the target level's base from `vbase_i` (slot k at bits k*AW upward), plus class times 0x80 (synchronous 0, IRQ 1, FIQ 2, system error 3), plus 0x200 when the target is above the current level.
- R9: The entry state word has the target level in [1:0], stack select set, all three mask bits set, and bits [7:6] copied from the input state word.
- R10: A return at level L outputs the link register and saved state of L. A return at EL0 is ignored. A return arriving together with a takeable exception is dropped, and the exception is taken.
- R11: `el_o` equals `state_o[1:0]`. `sp_sel_o` is that level when the stack select bit is set, and 0 otherwise.
- R12: `redirect_o` is high exactly in the cycle after an accepted entry or return. With no accepted event, `pc_o` and `state_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_req_i | input | 1 | Synchronous exception request |
| irq_req_i | input | 1 | Normal interrupt request |
| fiq_req_i | input | 1 | Fast interrupt request |
| serr_req_i | input | 1 | System error request |
| eret_i | input | 1 | Exception return strobe |
| route_sync_i | input | 2 | Routed level for synchronous exceptions |
| route_irq_i | input | 2 | Routed level for IRQ |
| route_fiq_i | input | 2 | Routed level for FIQ |
| route_serr_i | input | 2 | Routed level for system errors |
| vbase_i | input | 4*AW | Vector table base per level, level k at bits [k*AW +: AW] |
| pc_i | input | AW | PC of the current instruction |
| pstate_i | input | 8 | Current state word |
| redirect_o | output | 1 | New PC and state valid this cycle |
| pc_o | output | AW | Vector or return address |
| state_o | output | 8 | State word to adopt |
| el_o | output | 2 | New exception level |
| sp_sel_o | output | 2 | Level whose stack pointer is in use |

## Verification
Single requests are issued from each level, with routes above, equal to and below it and with masks both set and clear. This separates the three masking regimes and the 0x200 lower-level offset. Bursts of simultaneous requests, including a masked system error beside an unmasked FIQ, tell the priority order apart from the masking.

Entry/return pairs with stack select 0 and 1 show that banked state comes back for the correct level. A return at EL0, and a return that collides with an interrupt, show which event wins. A long run of random inputs is compared against a behavioural model on every clock.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
    localparam int NUM_EL    = 4;
    localparam int EL_W      = 2;
    localparam int STATE_W   = 8;
    localparam int NUM_CLS   = 4;
    // state word fields
    localparam int F_SPSEL   = 2;
    localparam int F_AMASK   = 3;
    localparam int F_IMASK   = 4;
    localparam int F_FMASK   = 5;
    // vector layout
    localparam int VEC_SHIFT = 7;      // 0x80 per class
    localparam int LOWER_OFS = 'h200;  // added when entering from below

    typedef logic [EL_W-1:0]    el_t;
    typedef logic [STATE_W-1:0] state_t;

    // encoding doubles as priority rank: higher value wins
    typedef enum logic [1:0] {
        CLS_SYNC = 2'd0,
        CLS_IRQ  = 2'd1,
        CLS_FIQ  = 2'd2,
        CLS_SERR = 2'd3
    } exc_cls_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_seq_pkg::*;
(
    input  el_t                      cur_el_i,
    input  logic [NUM_CLS-1:0]       req_i,    // indexed by class
    input  logic [NUM_CLS-1:1]       mask_i,   // async classes only
    input  logic [NUM_CLS*EL_W-1:0]  route_i,
    output logic                     take_o,
    output exc_cls_e                 cls_o,
    output el_t                      tgt_o,
    output logic                     lower_o
);
    logic [NUM_CLS-1:0] elig;
    el_t                tgt [NUM_CLS];

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        el_t raw;
        el_t lifted;
        assign raw    = route_i[c*EL_W +: EL_W];
        assign lifted = (raw == '0) ? el_t'(1) : raw;
        if (c == int'(CLS_SYNC)) begin : g_sync
            // never drop privilege: take the higher of route and current
            assign tgt[c]  = (lifted > cur_el_i) ? lifted : cur_el_i;
            assign elig[c] = req_i[c];
        end else begin : g_async
            assign tgt[c]  = lifted;
            assign elig[c] = req_i[c] &&
                             ((lifted > cur_el_i) ||
                              ((lifted == cur_el_i) && !mask_i[c]));
        end
    end

    always_comb begin
        take_o = 1'b0;
        cls_o  = CLS_SYNC;
        tgt_o  = tgt[0];
        for (int c = 0; c < NUM_CLS; c++) begin
            if (elig[c]) begin
                take_o = 1'b1;
                cls_o  = exc_cls_e'(2'(c));
                tgt_o  = tgt[c];
            end
        end
        lower_o = (tgt_o > cur_el_i);
    end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
    import exc_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [NUM_EL*AW-1:0] vbase_i,
    input  el_t                  tgt_i,
    input  exc_cls_e             cls_i,
    input  logic                 lower_i,
    output logic [AW-1:0]        addr_o
);
    logic [AW-1:0] base;
    logic [AW-1:0] ofs;

    assign base   = vbase_i[tgt_i*AW +: AW];
    assign ofs    = (AW'(cls_i) << VEC_SHIFT) | (lower_i ? AW'(LOWER_OFS) : '0);
    assign addr_o = base + ofs;
endmodule

// File: rtl/exc_bank.sv
module exc_bank
    import exc_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_i,
    input  el_t           save_lvl_i,
    input  state_t        save_state_i,
    input  logic [AW-1:0] save_pc_i,
    input  el_t           rd_lvl_i,
    output state_t        rd_state_o,
    output logic [AW-1:0] rd_pc_o
);
    typedef struct packed {
        state_t [NUM_EL-1:0]          spsv;
        logic   [NUM_EL-1:0][AW-1:0]  link;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (save_i) begin
            bank_d.spsv[save_lvl_i] = save_state_i;
            bank_d.link[save_lvl_i] = save_pc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign rd_state_o = bank_q.spsv[rd_lvl_i];
    assign rd_pc_o    = bank_q.link[rd_lvl_i];
endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
    import exc_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_req_i,
    input  logic                 irq_req_i,
    input  logic                 fiq_req_i,
    input  logic                 serr_req_i,
    input  logic                 eret_i,
    input  logic [1:0]           route_sync_i,
    input  logic [1:0]           route_irq_i,
    input  logic [1:0]           route_fiq_i,
    input  logic [1:0]           route_serr_i,
    input  logic [4*AW-1:0]      vbase_i,
    input  logic [AW-1:0]        pc_i,
    input  logic [7:0]           pstate_i,
    output logic                 redirect_o,
    output logic [AW-1:0]        pc_o,
    output logic [7:0]           state_o,
    output logic [1:0]           el_o,
    output logic [1:0]           sp_sel_o
);
    typedef struct packed {
        logic          redirect;
        logic [AW-1:0] pc;
        state_t        state;
        el_t           el;
        el_t           sp;
    } out_t;

    out_t          out_d, out_q;
    el_t           cur_el;
    logic          take, lower;
    exc_cls_e      cls;
    el_t           tgt;
    logic [AW-1:0] vec_addr;
    state_t        entry_state;
    state_t        ret_state;
    logic [AW-1:0] ret_pc;
    logic          ret_ok;

    assign cur_el = pstate_i[EL_W-1:0];

    exc_arbiter u_arb (
        .cur_el_i (cur_el),
        .req_i    ({serr_req_i, fiq_req_i, irq_req_i, sync_req_i}),
        .mask_i   ({pstate_i[F_AMASK], pstate_i[F_FMASK], pstate_i[F_IMASK]}),
        .route_i  ({route_serr_i, route_fiq_i, route_irq_i, route_sync_i}),
        .take_o   (take),
        .cls_o    (cls),
        .tgt_o    (tgt),
        .lower_o  (lower)
    );

    exc_vector #(.AW(AW)) u_vec (
        .vbase_i (vbase_i),
        .tgt_i   (tgt),
        .cls_i   (cls),
        .lower_i (lower),
        .addr_o  (vec_addr)
    );

    exc_bank #(.AW(AW)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .save_i       (take),
        .save_lvl_i   (tgt),
        .save_state_i (pstate_i),
        .save_pc_i    (pc_i),
        .rd_lvl_i     (cur_el),
        .rd_state_o   (ret_state),
        .rd_pc_o      (ret_pc)
    );

    always_comb begin
        entry_state                = pstate_i;
        entry_state[EL_W-1:0]      = tgt;
        entry_state[F_SPSEL]       = 1'b1;
        entry_state[F_AMASK]       = 1'b1;
        entry_state[F_IMASK]       = 1'b1;
        entry_state[F_FMASK]       = 1'b1;
    end

    // a return from EL0 is meaningless; an exception pre-empts a return
    assign ret_ok = eret_i && (cur_el != '0) && !take;

    always_comb begin
        out_d          = out_q;
        out_d.redirect = 1'b0;
        if (take) begin
            out_d.redirect = 1'b1;
            out_d.pc       = vec_addr;
            out_d.state    = entry_state;
        end else if (ret_ok) begin
            out_d.redirect = 1'b1;
            out_d.pc       = ret_pc;
            out_d.state    = ret_state;
        end
        out_d.el = out_d.state[EL_W-1:0];
        out_d.sp = out_d.state[F_SPSEL] ? out_d.state[EL_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign redirect_o = out_q.redirect;
    assign pc_o       = out_q.pc;
    assign state_o    = out_q.state;
    assign el_o       = out_q.el;
    assign sp_sel_o   = out_q.sp;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk
    import exc_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sync_req_i,
    input logic          irq_req_i,
    input logic          fiq_req_i,
    input logic          serr_req_i,
    input logic          eret_i,
    input logic [1:0]    route_irq_i,
    input logic [1:0]    route_serr_i,
    input logic [7:0]    pstate_i,
    input logic          redirect_o,
    input logic [AW-1:0] pc_o,
    input logic [7:0]    state_o
);
    logic any_req;
    assign any_req = sync_req_i | irq_req_i | fiq_req_i | serr_req_i;

    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_o |-> ($stable(pc_o) && $stable(state_o)));

    assert_high_route_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (serr_req_i && (route_serr_i > pstate_i[1:0])) |=>
        (redirect_o && state_o[F_AMASK] && state_o[F_IMASK] && state_o[F_FMASK]));

    assert_low_route_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_i && !sync_req_i && !fiq_req_i && !serr_req_i && !eret_i &&
         (route_irq_i != 2'd0) && (route_irq_i < pstate_i[1:0])) |=> !redirect_o);

    assert_no_priv_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !eret_i |=> (!redirect_o ||
                     ((state_o[1:0] >= $past(pstate_i[1:0])) && (state_o[1:0] != 2'd0))));

    assert_sync_entry_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req_i |=> (redirect_o && state_o[F_SPSEL] && state_o[F_AMASK] &&
                        state_o[F_IMASK] && state_o[F_FMASK]));

    assert_el0_return_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && !any_req && (pstate_i[1:0] == 2'd0)) |=> !redirect_o);
endmodule

bind exc_seq_ctrl exc_seq_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_req_i   (sync_req_i),
    .irq_req_i    (irq_req_i),
    .fiq_req_i    (fiq_req_i),
    .serr_req_i   (serr_req_i),
    .eret_i       (eret_i),
    .route_irq_i  (route_irq_i),
    .route_serr_i (route_serr_i),
    .pstate_i     (pstate_i),
    .redirect_o   (redirect_o),
    .pc_o         (pc_o),
    .state_o      (state_o)
);

// File: tb/exc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module exc_seq_ctrl_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_req, irq_req, fiq_req, serr_req, eret;
    logic [1:0]    r_sync, r_irq, r_fiq, r_serr;
    logic [4*AW-1:0] vbase;
    logic [AW-1:0] pc;
    logic [7:0]    pstate;
    logic          redirect_o;
    logic [AW-1:0] pc_o;
    logic [7:0]    state_o;
    logic [1:0]    el_o, sp_sel_o;

    logic [AW-1:0] vb [4];
    int n_checks = 0;
    int n_fail = 0;
    string tag = "R1";
    bit cmp_en = 0;

    always #4 clk = ~clk;

    exc_seq_ctrl #(.AW(AW)) u_exc_seq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .sync_req_i(sync_req), .irq_req_i(irq_req), .fiq_req_i(fiq_req),
        .serr_req_i(serr_req), .eret_i(eret),
        .route_sync_i(r_sync), .route_irq_i(r_irq), .route_fiq_i(r_fiq),
        .route_serr_i(r_serr), .vbase_i(vbase), .pc_i(pc), .pstate_i(pstate),
        .redirect_o(redirect_o), .pc_o(pc_o), .state_o(state_o),
        .el_o(el_o), .sp_sel_o(sp_sel_o)
    );

    // behavioural reference model
    logic [7:0]    m_spsv [4];
    logic [AW-1:0] m_link [4];
    logic          exp_redirect;
    logic [AW-1:0] exp_pc;
    logic [7:0]    exp_state;

    function automatic int lift(input logic [1:0] r);
        return (r == 2'd0) ? 1 : int'(r);
    endfunction

    function automatic bit can_take(input int t, input int cur, input logic m);
        return (t > cur) || ((t == cur) && !m);
    endfunction

    always @(posedge clk) begin
        int cur;
        int cls;
        int tgt;
        if (!rst_n) begin
            exp_redirect = 1'b0;
            exp_pc = '0;
            exp_state = '0;
            for (int k = 0; k < 4; k++) begin
                m_spsv[k] = '0;
                m_link[k] = '0;
            end
        end else begin
            cur = int'(pstate[1:0]);
            cls = -1;
            tgt = 0;
            if (serr_req && can_take(lift(r_serr), cur, pstate[3])) begin
                cls = 3; tgt = lift(r_serr);
            end else if (fiq_req && can_take(lift(r_fiq), cur, pstate[5])) begin
                cls = 2; tgt = lift(r_fiq);
            end else if (irq_req && can_take(lift(r_irq), cur, pstate[4])) begin
                cls = 1; tgt = lift(r_irq);
            end else if (sync_req) begin
                cls = 0; tgt = (lift(r_sync) > cur) ? lift(r_sync) : cur;
            end
            if (cls >= 0) begin
                m_spsv[tgt] = pstate;
                m_link[tgt] = pc;
                exp_pc = vb[tgt] + AW'(cls * 128) + ((tgt > cur) ? AW'(512) : AW'(0));
                exp_state = {pstate[7:6], 3'b111, 1'b1, 2'(tgt)};
                exp_redirect = 1'b1;
            end else if (eret && cur != 0) begin
                exp_pc = m_link[cur];
                exp_state = m_spsv[cur];
                exp_redirect = 1'b1;
            end else begin
                exp_redirect = 1'b0;
            end
        end
    end

    task automatic chk(input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            chk("redirect", AW'(redirect_o), AW'(exp_redirect));
            chk("pc", pc_o, exp_pc);
            chk("state", AW'(state_o), AW'(exp_state));
            chk("el R11", AW'(el_o), AW'(exp_state[1:0]));
            chk("sp R11", AW'(sp_sel_o), AW'(exp_state[2] ? exp_state[1:0] : 2'd0));
        end
    end

    task automatic idle();
        sync_req = 0; irq_req = 0; fiq_req = 0; serr_req = 0; eret = 0;
    endtask

    // hold the given stimulus for one clock, then return to idle
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    initial begin
        bit done;
        done = 0;
        idle();
        r_sync = 2'd1; r_irq = 2'd1; r_fiq = 2'd1; r_serr = 2'd1;
        for (int k = 0; k < 4; k++) vb[k] = 32'h1000_0000 + AW'(k) * 32'h0001_0000;
        vbase = {vb[3], vb[2], vb[1], vb[0]};
        pc = 32'h0000_0100;
        pstate = 8'h00;

        // R1: reset state
        repeat (3) @(negedge clk);
        tag = "R1";
        chk("reset redirect", AW'(redirect_o), '0);
        chk("reset pc", pc_o, '0);
        chk("reset state", AW'(state_o), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("post-reset pc", pc_o, '0);
        chk("post-reset sp", AW'(sp_sel_o), '0);
        cmp_en = 1;

        // R7: sync from EL0, stack select 0, routed to EL1
        tag = "R7";
        pstate = 8'hC0; pc = 32'h0000_0100; r_sync = 2'd1; sync_req = 1;
        step();
        // R10: return at EL1 restores saved word and link
        tag = "R10";
        pstate = 8'hFD; pc = 32'h0000_0AAA; eret = 1;
        step();
        // R11: return into EL2 with own stack pointer
        tag = "R11";
        pstate = 8'h06; pc = 32'h0000_2220; r_sync = 2'd3; sync_req = 1;
        step();
        pstate = 8'h3F; eret = 1;
        step();
        // R4: equal-level IRQ masked then unmasked
        tag = "R4";
        pstate = 8'h11; r_irq = 2'd1; irq_req = 1;
        step();
        pstate = 8'h01; irq_req = 1;
        step();
        // R3: higher-level FIQ taken despite mask
        tag = "R3";
        pstate = 8'h3A; r_fiq = 2'd3; fiq_req = 1;
        step();
        // R8: FIQ at same level, no lower-level offset
        tag = "R8";
        pstate = 8'h01; r_fiq = 2'd1; fiq_req = 1;
        step();
        // R5: IRQ routed below current level dropped
        tag = "R5";
        pstate = 8'h02; r_irq = 2'd1; irq_req = 1;
        step();
        // R2: priority among simultaneous requests
        tag = "R2";
        pstate = 8'h01; r_serr = 2'd3; r_fiq = 2'd3; r_irq = 2'd2; r_sync = 2'd1;
        serr_req = 1; fiq_req = 1; irq_req = 1; sync_req = 1;
        step();
        fiq_req = 1; irq_req = 1; sync_req = 1;
        step();
        irq_req = 1; sync_req = 1;
        step();
        pstate = 8'h09; r_serr = 2'd1; r_fiq = 2'd2; serr_req = 1; fiq_req = 1;
        step();
        // R6: route 0 means EL1; sync never below current
        tag = "R6";
        pstate = 8'h02; r_sync = 2'd0; sync_req = 1;
        step();
        pstate = 8'h00; r_irq = 2'd0; irq_req = 1;
        step();
        // R10: return at EL0 ignored, exception beats return
        tag = "R10";
        pstate = 8'h00; eret = 1;
        step();
        pstate = 8'h02; r_irq = 2'd3; irq_req = 1; eret = 1;
        step();
        // R9: entry keeps software bits
        tag = "R9";
        pstate = 8'h80; r_sync = 2'd2; sync_req = 1;
        step();
        // R12: idle cycles hold outputs while inputs wander
        tag = "R12";
        for (int i = 0; i < 5; i++) begin
            pc = pc + 32'h40;
            pstate = 8'(i);
            @(negedge clk);
        end
        // mixed random traffic
        tag = "random";
        for (int i = 0; i < 600; i++) begin
            sync_req = ($urandom % 6) == 0;
            irq_req  = ($urandom % 4) == 0;
            fiq_req  = ($urandom % 5) == 0;
            serr_req = ($urandom % 7) == 0;
            eret     = ($urandom % 3) == 0;
            r_sync = 2'($urandom); r_irq = 2'($urandom);
            r_fiq  = 2'($urandom); r_serr = 2'($urandom);
            pstate = 8'($urandom);
            pc = $urandom;
            @(negedge clk);
        end
        idle();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule